// File: doc/BRIEF.md
# Row-Parallel Bit-Serial Compute Memory

A small word-per-row memory in which every row is also a tiny arithmetic engine. Each row owns a circular shifter, a 1-bit ALU and two state bits. An operation compares or combines every selected row word with one broadcast operand. All selected rows work in the same cycle, one bit position per clock. The operation is an unsigned add, min or max. Rows whose select bit is clear stay untouched.

A host loads and inspects the rows through a plain addressed write port and a combinational read port. To run an operation it presents an operation code, a writeback choice, a row-select vector and the operand, then pulses `start`. It then waits for `done`.

Add walks the word from the least significant bit upward, with a carry bit in each row. Min and max walk from the most significant bit downward and latch the first differing bit as the decision. The chosen value is written only once all bits have been seen. Every row rotates through a full turn, so the stored word is back in its original bit alignment at the end.

Top module: `bitser_sram`

## Requirements
- R1: After reset every row reads 0, and `busy`, `done`, `busy_err` and every bit of `row_flag` are 0.
- R2: While idle, a write with `wr_en` high stores `wr_data` at `wr_addr` at the clock edge. `rd_data` always shows the row at `rd_addr` combinationally.
- R3: Op code 0 (add) with `wb` high replaces each selected row with (row + operand) mod 2^W. That row's `row_flag` bit becomes the carry out of bit W-1.
- R4: Rows whose `row_en` bit was clear when `start` was accepted keep their contents, and their `row_flag` bit reads 0 after the operation.
- R5: Op code 1 (min, unsigned) sets a selected row's flag when the operand is strictly less than the row. With `wb` high the row then takes the operand. On a tie the row is kept and the flag is 0.
- R6: Op codes 2 and 3 (max, unsigned) set the flag when the operand is strictly greater than the row. With `wb` high the row then takes the operand. On a tie the row is kept and the flag is 0.
- R7: With `wb` low, every op leaves all rows unchanged and still reports the flags.
- R8: `start` is accepted at a clock edge while not busy. `busy` is high from that edge until `done` rises. `done` is a one-cycle pulse that appears exactly W+1 clock edges after the accepting edge.
- R9: A write attempted while busy is dropped, and `busy_err` is high for the cycle after that edge.
- R10: A `start` pulse while busy is ignored: no extra `done` and no effect on the rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host row write strobe |
| wr_addr | input | AW | Row written |
| wr_data | input | W | Word written |
| rd_addr | input | AW | Row read |
| rd_data | output | W | Word at `rd_addr` |
| row_en | input | ROWS | Row-select vector sampled at start |
| op | input | 2 | 0 add, 1 min, 2 or 3 max |
| wb | input | 1 | Write the result back into the rows |
| operand | input | W | Broadcast operand |
| start | input | 1 | Begin an operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| busy_err | output | 1 | A write was rejected at the previous edge |
| row_flag | output | ROWS | Per-row carry (add) or operand-wins bit (min/max) |

## Verification
A faulty carry or decision bit in one row shows up at that row's `row_flag` bit at the `done` pulse. It also shows up in the row's word the first time it is read afterwards, so the error is caught within W+2 cycles of `start`. A shifter that rotates the wrong way or by the wrong amount leaves the word misaligned even when `wb` is low, so re-reading every row after each op exposes it. A counter off by one moves `done` by a cycle, and the cycle-stamped scoreboard notices at the pulse itself.

// File: rtl/bitser_sram.sv
module bitser_sram #(
  parameter int ROWS = 8,
  parameter int W    = 16,
  parameter int AW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic [ROWS-1:0] row_en,
  input  logic [1:0]      op,
  input  logic            wb,
  input  logic [W-1:0]    operand,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            busy_err,
  output logic [ROWS-1:0] row_flag
);
  localparam int CW = $clog2(W + 1);

  logic [ROWS-1:0][W-1:0] mem, step_mem;
  logic [ROWS-1:0]        st, dec, step_st, step_dec, enl;
  logic [W-1:0]           opnd, sh;
  logic [1:0]             opl;
  logic                   wbl;
  logic [CW-1:0]          cnt;
  logic                   is_add, is_max, b;

  assign is_add   = (opl == 2'd0);
  assign is_max   = opl[1];
  assign b        = is_add ? sh[0] : sh[W-1];
  assign rd_data  = mem[rd_addr];
  assign row_flag = st;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      step_st[r]  = st[r];
      step_dec[r] = dec[r];
      if (is_add) begin
        step_mem[r] = {wbl ? (mem[r][0] ^ b ^ st[r]) : mem[r][0], mem[r][W-1:1]};
        step_st[r]  = (mem[r][0] & b) | (st[r] & (mem[r][0] ^ b));
      end else begin
        step_mem[r] = {mem[r][W-2:0], mem[r][W-1]};
        if (!dec[r] && (mem[r][W-1] != b)) begin
          step_dec[r] = 1'b1;
          step_st[r]  = is_max ? b : ~b;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem      <= '0;
      st       <= '0;
      dec      <= '0;
      enl      <= '0;
      opnd     <= '0;
      sh       <= '0;
      opl      <= '0;
      wbl      <= 1'b0;
      cnt      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      busy_err <= wr_en && busy;
      if (!busy) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          opl  <= op;
          wbl  <= wb;
          enl  <= row_en;
          opnd <= operand;
          sh   <= operand;
          st   <= '0;
          dec  <= '0;
        end
      end else if (cnt != CW'(W)) begin
        cnt <= cnt + 1'b1;
        sh  <= is_add ? {1'b0, sh[W-1:1]} : {sh[W-2:0], 1'b0};
        for (int r = 0; r < ROWS; r++)
          if (enl[r]) begin
            mem[r] <= step_mem[r];
            st[r]  <= step_st[r];
            dec[r] <= step_dec[r];
          end
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!is_add && wbl)
          for (int r = 0; r < ROWS; r++)
            if (enl[r] && st[r]) mem[r] <= opnd;
      end
    end
  end
endmodule

// File: rtl/bitser_sram_chk.sv
module bitser_sram_chk #(
  parameter int ROWS = 8,
  parameter int W    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   wr_en,
  input logic                   busy_err,
  input logic [ROWS-1:0]        enl,
  input logic [ROWS-1:0][W-1:0] mem
);
  int ccnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ccnt <= 0;
    else if (start && !busy) ccnt <= 0;
    else if (busy) ccnt <= ccnt + 1;
  end

  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccnt == W + 1));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> busy_err);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> $past(busy && wr_en));

  for (genvar r = 0; r < ROWS; r++) begin : g_hold
    p_idle_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !enl[r]) |=> $stable(mem[r]));
  end
endmodule

bind bitser_sram bitser_sram_chk #(.ROWS(ROWS), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .busy_err(busy_err), .enl(enl), .mem(mem)
);

// File: tb/test_bitser_sram.sv
`timescale 1ns/1ps
module test_bitser_sram;
  localparam int ROWS = 8, W = 16, AW = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, wb = 0, start = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, operand = '0, rd_data;
  logic [ROWS-1:0] row_en = '0, row_flag;
  logic [1:0] op = '0;
  logic busy, done, busy_err;

  bitser_sram #(.ROWS(ROWS), .W(W)) i_bitser_sram (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [W-1:0] m [ROWS];
  logic [ROWS-1:0] fq [$];
  int cq [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    if (fq.size() == 0) check("R10 unexpected done", 1, 0);
    else begin
      check("R3-flags", {24'd0, row_flag}, {24'd0, fq.pop_front()});
      check("R8 done cycle", cyc, cq.pop_front());
    end
  end

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
    m[a] = d;
  endtask

  task automatic rd_all(string req);
    for (int r = 0; r < ROWS; r++) begin
      rd_addr = AW'(r); #0.1;
      check(req, {16'd0, rd_data}, {16'd0, m[r]});
    end
  endtask

  task automatic run(logic [1:0] o, logic w, logic [ROWS-1:0] en, logic [W-1:0] x, int mode);
    logic [ROWS-1:0] f = '0;
    logic [W:0] s;
    for (int r = 0; r < ROWS; r++) if (en[r]) begin
      if (o == 0) begin
        s = {1'b0, m[r]} + {1'b0, x}; f[r] = s[W];
        if (w) m[r] = s[W-1:0];
      end else begin
        f[r] = (o == 1) ? (x < m[r]) : (x > m[r]);
        if (w && f[r]) m[r] = x;
      end
    end
    @(negedge clk);
    op = o; wb = w; row_en = en; operand = x; start = 1;
    fq.push_back(f); cq.push_back(cyc + 1 + W + 1);
    @(negedge clk); start = 0;
    check("R8 busy after start", busy, 1);
    if (mode == 1) begin
      wr_en = 1; wr_addr = 0; wr_data = 16'hDEAD;
      @(negedge clk); wr_en = 0;
      check("R9 busy_err", busy_err, 1);
    end else if (mode == 2) begin
      start = 1; op = 0; wb = 1; row_en = '1; operand = 16'h1111;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    check("R8 done pulse", done, 1);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 busy cleared", busy, 0);
  endtask

  initial begin
    #500000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 busy_err", busy_err, 0); check("R1 flags", row_flag, 0);
    rd_all("R1 rows");

    wr(0, 16'h0001); wr(1, 16'hFFFF); wr(2, 16'hF000); wr(3, 16'h1234);
    wr(4, 16'h4000); wr(5, 16'h8000); wr(6, 16'h3FFF); wr(7, 16'h7ABC);
    rd_all("R2 write/read");

    run(0, 1, 8'hFF, 16'h1234, 0);  rd_all("R3 add wb");
    run(0, 1, 8'h55, 16'hF00F, 0);  rd_all("R4 disabled rows");
    check("R4 disabled flags", row_flag & 8'hAA, 0);
    wr(3, 16'h4000);
    run(1, 1, 8'hFF, 16'h4000, 0);  rd_all("R5 min wb");
    run(2, 1, 8'hFF, 16'h8001, 0);  rd_all("R6 max wb");
    run(3, 1, 8'h0F, 16'hC000, 0);  rd_all("R6 max code3");
    run(0, 0, 8'hFF, 16'hFFFF, 0);  rd_all("R7 add no wb");
    run(1, 0, 8'hFF, 16'h0000, 0);  rd_all("R7 min no wb");
    run(0, 1, 8'hFF, 16'h0101, 1);  rd_all("R9 write dropped");
    run(2, 1, 8'h3C, 16'h9000, 2);  rd_all("R10 start ignored");
    repeat (W + 4) @(negedge clk);
    check("R10 no pending", fq.size(), 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule